// File: doc/BRIEF.md
# Morse Letter Blinker

The block shows one of eight letters (A to H) as Morse code on a single lamp output. A 3-bit letter select is captured when a start request arrives while the block is idle. The letter's dots and dashes are then played one after another, with a dark pause between symbols. After the last symbol the block returns to idle with the lamp off.

All timing is built from one unit of half a second. A tick generator divides the system clock by `HALF_SEC_CYCLES` to mark each unit. The default of 25,000,000 suits a 50 MHz clock, and a bench can use a small value. The tick generator is held clear while idle, so the first symbol always lasts its full length. An active-low asynchronous reset forces idle with the lamp off.

States and transitions: `ST_IDLE` goes to `ST_MARK` on a start request and captures the letter. `ST_MARK` goes to `ST_SPACE` when a symbol other than the last has run its length, and to `ST_IDLE` when the last symbol has run its length. `ST_SPACE` goes to `ST_MARK` after one unit and moves to the next symbol.

Top module: `morse_blinker`

## Requirements
- R1: `letter_sel` picks the letter: 0 is A, 1 is B, 2 is C, 3 is D, 4 is E, 5 is F, 6 is G and 7 is H. The symbol sequences are A .-, B -..., C -.-., D -.., E ., F ..-., G --. and H ....
- R2: One unit is `HALF_SEC_CYCLES` clock cycles. A dot holds `led` high for 1 unit and a dash holds it high for 3 units.
- R3: Within a letter, `led` is low for exactly 1 unit between symbols. Playback ends right after the last lit symbol, with no trailing pause.
- R4: If `start` is high at a clock edge while idle, `led` and `busy` go high in the next cycle. The first symbol lasts its full length however long the block was idle before.
- R5: While `busy` is high, `start` has no effect on the sequence being played.
- R6: The letter is captured at start. Changes to `letter_sel` during playback have no effect.
- R7: `busy` is high from the cycle after the start request until the last symbol ends, and low at all other times. `led` is never high while `busy` is low.
- R8: Asserting `rst_n` low forces `led` and `busy` low at once, without a clock edge. After release, the block waits idle for a start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, sampled at clock edges while idle |
| letter_sel | input | 3 | Letter code, 0 = A through 7 = H |
| led | output | 1 | Lamp drive, high while a symbol is lit |
| busy | output | 1 | High while a letter is being played |

## Verification
A wrong captured pattern or a wrong symbol index shows on `led` as a wrong lit length at the first symbol affected: a dot stretched to three units or a dash cut to one. This shows within three units of the fault. A bad length or a bad unit counter shows at the end of the letter, where `busy` drops too early or too late. Errors in the tick generator or in its clearing show in the first symbol as a lit length that is not an exact multiple of `HALF_SEC_CYCLES`. The bench compares `led` and `busy` on every cycle of every playback. This places each fault in the exact cycle where it appears.

// File: rtl/morse_pkg.sv
package morse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MARK  = 2'd1,
        ST_SPACE = 2'd2
    } blink_state_t;

    // dashes[i] = 1 means symbol i (sent i-th) is a dash
    typedef struct packed {
        logic [3:0] dashes;
        logic [1:0] last;
    } letter_code_t;

    localparam int unsigned DOT_UNITS  = 1;
    localparam int unsigned DASH_UNITS = 3;

    function automatic letter_code_t letter_lookup(input logic [2:0] code);
        letter_code_t r;
        unique case (code)
            3'd0: r = '{dashes: 4'b0010, last: 2'd1}; // A .-
            3'd1: r = '{dashes: 4'b0001, last: 2'd3}; // B -...
            3'd2: r = '{dashes: 4'b0101, last: 2'd3}; // C -.-.
            3'd3: r = '{dashes: 4'b0001, last: 2'd2}; // D -..
            3'd4: r = '{dashes: 4'b0000, last: 2'd0}; // E .
            3'd5: r = '{dashes: 4'b0100, last: 2'd3}; // F ..-.
            3'd6: r = '{dashes: 4'b0011, last: 2'd2}; // G --.
            3'd7: r = '{dashes: 4'b0000, last: 2'd3}; // H ....
            default: r = '{dashes: 4'b0000, last: 2'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/morse_tick_gen.sv
module morse_tick_gen #(
    parameter int unsigned PERIOD = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST) && !clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/morse_letter_rom.sv
module morse_letter_rom
    import morse_pkg::*;
(
    input  logic [2:0] sel,
    output logic [3:0] dashes,
    output logic [1:0] last
);
    letter_code_t code;

    always_comb begin
        code   = letter_lookup(sel);
        dashes = code.dashes;
        last   = code.last;
    end
endmodule

// File: rtl/morse_seq_fsm.sv
module morse_seq_fsm
    import morse_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [3:0] rom_dashes,
    input  logic [1:0] rom_last,
    output logic       led,
    output logic       busy,
    output logic       tick_clear
);
    localparam logic [1:0] DOT_END  = 2'(DOT_UNITS - 1);
    localparam logic [1:0] DASH_END = 2'(DASH_UNITS - 1);

    blink_state_t state_q, state_d;
    logic [3:0]   pat_q;
    logic [1:0]   last_q;
    logic [1:0]   idx_q;
    logic [1:0]   units_q;
    logic [1:0]   sym_end;
    logic         sym_done;

    assign sym_end  = pat_q[idx_q] ? DASH_END : DOT_END;
    assign sym_done = tick && (units_q == sym_end);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_MARK;
            ST_MARK:  if (sym_done) state_d = (idx_q == last_q) ? ST_IDLE : ST_SPACE;
            ST_SPACE: if (tick) state_d = ST_MARK;
            default:  state_d = ST_IDLE;
        endcase
    end

    // letter capture and position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q   <= '0;
            last_q  <= '0;
            idx_q   <= '0;
            units_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    pat_q   <= rom_dashes;
                    last_q  <= rom_last;
                    idx_q   <= '0;
                    units_q <= '0;
                end
                ST_MARK: if (tick) units_q <= sym_done ? 2'd0 : units_q + 2'd1;
                ST_SPACE: if (tick) idx_q <= idx_q + 2'd1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        led        = 1'b0;
        busy       = 1'b1;
        tick_clear = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin busy = 1'b0; tick_clear = 1'b1; end
            ST_MARK:  led = 1'b1;
            ST_SPACE: ;
            default:  begin busy = 1'b0; tick_clear = 1'b1; end
        endcase
    end
endmodule

// File: rtl/morse_blinker.sv
module morse_blinker #(
    parameter int unsigned HALF_SEC_CYCLES = 25_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] letter_sel,
    output logic       led,
    output logic       busy
);
    logic       tick;
    logic       tick_clear;
    logic [3:0] rom_dashes;
    logic [1:0] rom_last;

    morse_tick_gen #(.PERIOD(HALF_SEC_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tick_clear),
        .tick  (tick)
    );

    morse_letter_rom u_rom (
        .sel    (letter_sel),
        .dashes (rom_dashes),
        .last   (rom_last)
    );

    morse_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start      (start),
        .rom_dashes (rom_dashes),
        .rom_last   (rom_last),
        .led        (led),
        .busy       (busy),
        .tick_clear (tick_clear)
    );
endmodule

// File: rtl/morse_blinker_chk.sv
module morse_blinker_chk #(
    parameter int unsigned HC = 25_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic led,
    input logic busy
);
    int unsigned lit_run;
    int unsigned dark_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lit_run  <= 0;
            dark_run <= 0;
        end else begin
            lit_run  <= led ? lit_run + 1 : 0;
            dark_run <= (busy && !led) ? dark_run + 1 : 0;
        end
    end

    // R2
    lit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(led) |-> (lit_run == HC || lit_run == 3 * HC));

    // R3
    gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(led) && $past(busy)) |-> (dark_run == HC));

    // R3
    end_after_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(led));

    // R7
    led_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        led |-> busy);

    // R4
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R5
    gap_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !led) |=> busy);
endmodule

bind morse_blinker morse_blinker_chk #(.HC(HALF_SEC_CYCLES)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .led   (led),
    .busy  (busy)
);

// File: tb/sim_morse_blinker.sv
`timescale 1ns/1ps
module sim_morse_blinker;
    localparam int unsigned HC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] letter_sel = 3'd0;
    logic       led, busy;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    morse_blinker #(.HALF_SEC_CYCLES(HC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .letter_sel(letter_sel), .led(led), .busy(busy)
    );

    // R1 letter table, written as symbol strings
    function automatic string code_of(input int l);
        case (l)
            0: return ".-";
            1: return "-...";
            2: return "-.-.";
            3: return "-..";
            4: return ".";
            5: return "..-.";
            6: return "--.";
            default: return "....";
        endcase
    endfunction

    task automatic check(input logic got, input logic exp, input string req, input string what);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    // one cycle of playback: check, optionally disturb inputs, advance
    task automatic step(input logic exp_led, input bit noisy, input string req);
        check(led, exp_led, req, "led");
        check(busy, 1'b1, "R7", "busy");
        if (noisy) begin
            start      = ($urandom % 3) == 0;   // R5 stray presses
            letter_sel = 3'($urandom);          // R6 select changes
        end
        @(negedge clk);
    endtask

    task automatic play(input int l, input bit noisy, input int idle_cycles);
        string s;
        s = code_of(l);
        for (int i = 0; i < idle_cycles; i++) begin
            check(led, 1'b0, "R7", "idle led");
            check(busy, 1'b0, "R7", "idle busy");
            @(negedge clk);
        end
        letter_sel = 3'(l);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < s.len(); k++) begin
            int units;
            units = (s[k] == "-") ? 3 : 1;
            for (int c = 0; c < units * int'(HC); c++)
                step(1'b1, noisy, k == 0 ? "R4" : (units == 3 ? "R2" : "R1"));
            if (k != s.len() - 1)
                for (int c = 0; c < int'(HC); c++)
                    step(1'b0, noisy, "R3");
        end
        check(led, 1'b0, "R3", "end led");
        check(busy, 1'b0, "R3", "end busy");
        start = 1'b0;
        @(negedge clk);
        check(busy, 1'b0, "R5", "no restart from stray press");
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        #35;
        check(led, 1'b0, "R8", "reset led");
        check(busy, 1'b0, "R8", "reset busy");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // directed: every letter, clean and disturbed
        for (int l = 0; l < 8; l++) play(l, 1'b0, l);
        for (int l = 0; l < 8; l++) play(l, 1'b1, 1);
        // random
        for (int n = 0; n < 30; n++) play(int'($urandom % 8), 1'($urandom), int'($urandom % 9));
        // R8 async reset mid-playback
        letter_sel = 3'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        #3 rst_n = 1'b0;
        #1;
        check(led, 1'b0, "R8", "async led");
        check(busy, 1'b0, "R8", "async busy");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(busy, 1'b0, "R8", "idle after reset");
        end
        play(1, 1'b0, 2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule